// File: doc/BRIEF.md
# Common Interface Slot Controller

This block sits between a host register port and two conditional-access module slots. A handful of byte-wide control registers are shared by both slots. The host stores a 14-bit module address across two address registers and chooses a slot and an address space (attribute memory or control space) in the bus-control register. Each access to the data register then runs one strobed read or write cycle on the module bus. The setup, strobe and hold lengths are parameters, and the host sees completion only after the hold time has ended.

The same bus-control byte also starts a per-slot module reset, which clears itself, and holds the per-slot transport-stream gates. It also reports whether a card is present in each slot. A second control byte carries the two stream-output enables and two active-low tuner reset lines, which software pulses. Each card-detect input is synchronised and debounced. A change in either debounced presence bit raises a sticky interrupt request, and the host clears it by reading the interrupt register.

Top module: `ci_slot_ctrl`

## Requirements
- R1: After reset, bus control (offset 0) reads 8'h03, bus control 2 (offset 1) reads 8'h0C, the interrupt register (offset 5) reads 0, all module chip enables are high (inactive) and all reset and stream-enable outputs are low.
- R2: The address-low register (offset 2) supplies module address bits 6:0 from its bits 7:1, and its bit 0 reads as 0. The address-high register (offset 3) supplies bits 13:7 from its bits 6:0, and its bit 7 reads as 0.
- R3: A read of the data register (offset 4) asserts the chip enable of the slot given by bus-control bit 7 (0 = slot 0, driving mod_ce_n[0] low). It drives mod_space from bus-control bit 6 (1 = control space, 0 = attribute memory) and returns the module data sampled at the end of the read strobe.
- R4: A write of the data register drives the written byte on mod_dout with mod_doe high while mod_we_n is low, on the selected slot, space and address.
- R5: In each data access, the chip enable is active for SETUP_CYC clocks before the strobe. The strobe stays low for PULSE_CYC clocks, and the chip enable stays active for HOLD_CYC clocks after the strobe. rsp_done follows after that.
- R6: The read and write strobes are never low together, and at most one chip enable is active at a time.
- R7: Writing 1 to bus-control bit 5 (slot 0) or bit 4 (slot 1) drives that slot's mod_rst high for RST_HOLD_CYC clocks. The bit reads 1 until the sequence ends, and it clears once mod_rdy of that slot is high after the hold.
- R8: If mod_rdy stays low, the reset bit clears RST_TMO_CYC clocks after the hold ends, with mod_rst already released.
- R9: Writing 0 to a reset bit while that reset is in progress has no effect. Writes to bus-control bits 1:0 have no effect.
- R10: Bus-control bit 3 drives ts_en[0] and bit 2 drives ts_en[1]. Bus-control-2 bit 4 drives ts_out_en[0] and bit 5 drives ts_out_en[1].
- R11: Bus-control-2 bit 3 drives tuner_rst_n[0] and bit 2 drives tuner_rst_n[1].
- R12: Bus-control bit 1 reports slot 0 and bit 0 reports slot 1, where 0 means a card is present. The value is card_det_n after synchronisation and a debounce of DB_CYC stable clocks, so a pulse shorter than that is ignored.
- R13: Any change of a debounced presence bit sets the pending flag, which drives irq. Reading the interrupt register returns the flag in bit 0 and clears it, and a new change in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request strobe (ignored while a module access runs) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_done |
| irq | output | 1 | Pending presence-change interrupt |
| card_det_n | input | 2 | Per-slot card detect, low = present |
| mod_rdy | input | 2 | Per-slot module ready |
| mod_addr | output | 14 | Module address |
| mod_din | input | 8 | Module read data |
| mod_dout | output | 8 | Module write data |
| mod_doe | output | 1 | Write data drive enable |
| mod_ce_n | output | 2 | Per-slot chip enable, active low |
| mod_oe_n | output | 1 | Read strobe, active low |
| mod_we_n | output | 1 | Write strobe, active low |
| mod_space | output | 1 | 1 = control space, 0 = attribute memory |
| mod_rst | output | 2 | Per-slot module reset, active high |
| ts_en | output | 2 | Per-slot stream path enable |
| ts_out_en | output | 2 | Stream output enables |
| tuner_rst_n | output | 2 | Tuner resets, active low |

## Verification
The bench builds the block with setup 2, pulse 3, hold 2, a reset hold of 8 clocks, a ready timeout of 40 clocks and a debounce of 4 clocks. With these short values, both the ready-driven and the timeout-driven ends of the reset sequence, a sub-debounce glitch and exact strobe-phase counts can all be observed within a few hundred clocks. A distinct strobe-phase length makes an off-by-one in any one phase visible.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int NSLOT  = 2;
  localparam int REG_AW = 3;
  localparam int MOD_AW = 14;

  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t A_CTRL  = 3'd0;
  localparam reg_addr_t A_CTRL2 = 3'd1;
  localparam reg_addr_t A_ALO   = 3'd2;
  localparam reg_addr_t A_AHI   = 3'd3;
  localparam reg_addr_t A_DATA  = 3'd4;
  localparam reg_addr_t A_IRQ   = 3'd5;

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_PULSE, B_HOLD} bus_st_e;
  typedef enum logic [1:0] {R_IDLE, R_HOLD, R_WAIT} rst_st_e;
endpackage

// File: rtl/ci_bus_cycle.sv
module ci_bus_cycle
  import ci_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 4,
  parameter int HOLD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       slot,
  input  logic [7:0] mod_din,
  output logic       busy,
  output logic [1:0] ce_n,
  output logic       oe_n,
  output logic       we_n,
  output logic [7:0] dout,
  output logic       doe,
  output logic       done,
  output logic [7:0] rdata
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);

  bus_st_e       st;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic          slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= B_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b0;
      slot_q <= 1'b0;
      dout   <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        B_IDLE: if (start) begin
          st     <= B_SETUP;
          cnt    <= CW'(SETUP_CYC - 1);
          wr_q   <= wr;
          slot_q <= slot;
          dout   <= wdata;
        end
        B_SETUP: if (cnt == '0) begin
          st  <= B_PULSE;
          cnt <= CW'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        B_PULSE: if (cnt == '0) begin
          if (!wr_q) rdata <= mod_din;
          st  <= B_HOLD;
          cnt <= CW'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          st   <= B_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy = (st != B_IDLE);
  assign ce_n = busy ? (slot_q ? 2'b01 : 2'b10) : 2'b11;
  assign oe_n = !((st == B_PULSE) && !wr_q);
  assign we_n = !((st == B_PULSE) && wr_q);
  assign doe  = busy && wr_q;
endmodule

// File: rtl/ci_reset_seq.sv
module ci_reset_seq
  import ci_pkg::*;
#(
  parameter int HOLD_CYC = 1000,
  parameter int TMO_CYC  = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ready,
  output logic mod_rst,
  output logic busy
);
  localparam int MAXC = (HOLD_CYC > TMO_CYC) ? HOLD_CYC : TMO_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  rst_st_e       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= R_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        R_IDLE: if (start) begin
          st  <= R_HOLD;
          cnt <= CW'(HOLD_CYC - 1);
        end
        R_HOLD: if (cnt == '0) begin
          st  <= R_WAIT;
          cnt <= CW'(TMO_CYC - 1);
        end else cnt <= cnt - 1'b1;
        default: if (ready || cnt == '0) st <= R_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign mod_rst = (st == R_HOLD);
  assign busy    = (st != R_IDLE);
endmodule

// File: rtl/ci_debounce.sv
module ci_debounce #(
  parameter int DB_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level,
  output logic changed
);
  localparam int CW = $clog2(DB_CYC + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      level   <= 1'b1;
      cnt     <= '0;
      changed <= 1'b0;
    end else begin
      s1      <= raw;
      s2      <= s1;
      changed <= 1'b0;
      if (s2 != level) begin
        if (cnt == CW'(DB_CYC - 1)) begin
          level   <= s2;
          cnt     <= '0;
          changed <= 1'b1;
        end else cnt <= cnt + 1'b1;
      end else cnt <= '0;
    end
  end
endmodule

// File: rtl/ci_slot_ctrl.sv
module ci_slot_ctrl
  import ci_pkg::*;
#(
  parameter int SETUP_CYC    = 2,
  parameter int PULSE_CYC    = 4,
  parameter int HOLD_CYC     = 2,
  parameter int RST_HOLD_CYC = 1000,
  parameter int RST_TMO_CYC  = 100000,
  parameter int DB_CYC       = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_done,
  output logic [7:0]        rsp_rdata,
  output logic              irq,
  input  logic [NSLOT-1:0]  card_det_n,
  input  logic [NSLOT-1:0]  mod_rdy,
  output logic [MOD_AW-1:0] mod_addr,
  input  logic [7:0]        mod_din,
  output logic [7:0]        mod_dout,
  output logic              mod_doe,
  output logic [NSLOT-1:0]  mod_ce_n,
  output logic              mod_oe_n,
  output logic              mod_we_n,
  output logic              mod_space,
  output logic [NSLOT-1:0]  mod_rst,
  output logic [NSLOT-1:0]  ts_en,
  output logic [NSLOT-1:0]  ts_out_en,
  output logic [NSLOT-1:0]  tuner_rst_n
);
  logic             slot_q, space_q;
  logic [1:0]       ts_q, out_q, tun_q;
  logic [6:0]       alo_q, ahi_q;
  logic             irq_q;
  logic [NSLOT-1:0] rst_go, rst_busy, absent, det_chg;
  logic             bus_busy, bus_done;
  logic [7:0]       bus_rdata, rd_val;
  logic             accept, wr_acc, rd_acc, is_data;

  assign accept  = req_valid && !bus_busy;
  assign is_data = (req_addr == A_DATA);
  assign wr_acc  = accept && req_write;
  assign rd_acc  = accept && !req_write;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign rst_go[s] = wr_acc && (req_addr == A_CTRL) && req_wdata[5-s];

    ci_reset_seq #(.HOLD_CYC(RST_HOLD_CYC), .TMO_CYC(RST_TMO_CYC)) u_rst (
      .clk(clk), .rst(rst), .start(rst_go[s]), .ready(mod_rdy[s]),
      .mod_rst(mod_rst[s]), .busy(rst_busy[s]));

    ci_debounce #(.DB_CYC(DB_CYC)) u_db (
      .clk(clk), .rst(rst), .raw(card_det_n[s]),
      .level(absent[s]), .changed(det_chg[s]));
  end

  ci_bus_cycle #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)) u_bus (
    .clk(clk), .rst(rst), .start(accept && is_data), .wr(req_write),
    .wdata(req_wdata), .slot(slot_q), .mod_din(mod_din), .busy(bus_busy),
    .ce_n(mod_ce_n), .oe_n(mod_oe_n), .we_n(mod_we_n), .dout(mod_dout),
    .doe(mod_doe), .done(bus_done), .rdata(bus_rdata));

  always_comb begin
    case (req_addr)
      A_CTRL:  rd_val = {slot_q, space_q, rst_busy[0], rst_busy[1],
                         ts_q[0], ts_q[1], absent[0], absent[1]};
      A_CTRL2: rd_val = {2'b00, out_q[1], out_q[0], tun_q[0], tun_q[1], 2'b00};
      A_ALO:   rd_val = {alo_q, 1'b0};
      A_AHI:   rd_val = {1'b0, ahi_q};
      A_IRQ:   rd_val = {7'd0, irq_q};
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q    <= 1'b0;
      space_q   <= 1'b0;
      ts_q      <= '0;
      out_q     <= '0;
      tun_q     <= 2'b11;
      alo_q     <= '0;
      ahi_q     <= '0;
      irq_q     <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= (accept && !is_data) || bus_done;
      if (accept && !is_data) rsp_rdata <= rd_val;
      else if (bus_done)      rsp_rdata <= bus_rdata;

      if (wr_acc) begin
        case (req_addr)
          A_CTRL: begin
            slot_q  <= req_wdata[7];
            space_q <= req_wdata[6];
            ts_q    <= {req_wdata[2], req_wdata[3]};
          end
          A_CTRL2: begin
            out_q <= req_wdata[5:4];
            tun_q <= {req_wdata[2], req_wdata[3]};
          end
          A_ALO:   alo_q <= req_wdata[7:1];
          A_AHI:   ahi_q <= req_wdata[6:0];
          default: ;
        endcase
      end

      if (|det_chg)                          irq_q <= 1'b1;
      else if (rd_acc && req_addr == A_IRQ) irq_q <= 1'b0;
    end
  end

  assign mod_addr    = {ahi_q, alo_q};
  assign mod_space   = space_q;
  assign ts_en       = ts_q;
  assign ts_out_en   = out_q;
  assign tuner_rst_n = tun_q;
  assign irq         = irq_q;
endmodule

// File: rtl/ci_slot_ctrl_chk.sv
module ci_slot_ctrl_chk
  import ci_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [REG_AW-1:0] req_addr,
  input logic              irq,
  input logic [MOD_AW-1:0] mod_addr,
  input logic              mod_doe,
  input logic [NSLOT-1:0]  mod_ce_n,
  input logic              mod_oe_n,
  input logic              mod_we_n,
  input logic [NSLOT-1:0]  mod_rst
);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mod_oe_n && !mod_we_n));

  // R6
  ce_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mod_ce_n));

  // R5
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (rst)
    (!mod_oe_n || !mod_we_n) |-> (mod_ce_n != 2'b11));

  // R5
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    ((mod_ce_n != 2'b11) && ($past(mod_ce_n) != 2'b11)) |-> $stable(mod_addr));

  // R4
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !mod_we_n |-> mod_doe);

  // R7
  rst_held_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_rst[0]) |=> mod_rst[0]);

  // R13
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !(req_valid && !req_write && req_addr == A_IRQ)) |=> irq);
endmodule

bind ci_slot_ctrl ci_slot_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .irq(irq), .mod_addr(mod_addr), .mod_doe(mod_doe),
  .mod_ce_n(mod_ce_n), .mod_oe_n(mod_oe_n), .mod_we_n(mod_we_n),
  .mod_rst(mod_rst));

// File: tb/ci_slot_ctrl_test.sv
module ci_slot_ctrl_test;
  import ci_pkg::*;

  localparam int SETUP = 2, PULSE = 3, HOLD = 2, RHOLD = 8, RTMO = 40, DB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [REG_AW-1:0] req_addr = '0;
  logic [7:0]        req_wdata = '0;
  logic              rsp_done, irq, mod_doe, mod_oe_n, mod_we_n, mod_space;
  logic [7:0]        rsp_rdata, mod_dout, mod_din;
  logic [1:0]        card_det_n = 2'b11, mod_rdy = 2'b11;
  logic [1:0]        mod_ce_n, mod_rst, ts_en, ts_out_en, tuner_rst_n;
  logic [MOD_AW-1:0] mod_addr;

  ci_slot_ctrl #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
                 .RST_HOLD_CYC(RHOLD), .RST_TMO_CYC(RTMO), .DB_CYC(DB)) uut (.*);

  function automatic logic [7:0] model(input logic [13:0] a, input logic sp, input logic sl);
    return a[7:0] ^ a[13:6] ^ (sp ? 8'hA5 : 8'h3C) ^ (sl ? 8'hFF : 8'h00);
  endfunction
  assign mod_din = model(mod_addr, mod_space, !mod_ce_n[1]);

  int checks = 0, errors = 0, done_cnt = 0;
  int n_setup = 0, n_pulse = 0, n_hold = 0, n_rst0 = 0;
  logic [13:0] w_addr;
  logic [7:0]  w_data;
  logic [1:0]  w_ce;
  logic        w_space;

  logic [8:0] exp_q[$];
  logic [7:0] mask_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mod_ce_n != 2'b11) begin
      if (!mod_oe_n || !mod_we_n) n_pulse++;
      else if (n_pulse == 0) n_setup++;
      else n_hold++;
    end
    if (mod_rst[0]) n_rst0++;
    if (!mod_we_n) begin
      w_addr = mod_addr; w_data = mod_dout; w_ce = mod_ce_n; w_space = mod_space;
    end
    if (!rst && rsp_done) begin
      logic [8:0] e;
      logic [7:0] m;
      string t;
      e = exp_q.pop_front(); m = mask_q.pop_front(); t = tag_q.pop_front();
      if (e[8]) check((rsp_rdata & m) == (e[7:0] & m), t, rsp_rdata & m, e[7:0] & m);
      done_cnt++;
    end
  end

  task automatic access(input bit wr, input reg_addr_t a, input logic [7:0] d,
                        input bit chk, input logic [7:0] exp, input logic [7:0] mask,
                        input string tag);
    int target;
    target = done_cnt + 1;
    exp_q.push_back({chk, exp}); mask_q.push_back(mask); tag_q.push_back(tag);
    n_setup = 0; n_pulse = 0; n_hold = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt < target) @(negedge clk);
  endtask

  task automatic wr(input reg_addr_t a, input logic [7:0] d);
    access(1'b1, a, d, 1'b0, 8'h00, 8'h00, "wr");
  endtask

  task automatic rd(input reg_addr_t a, input logic [7:0] exp, input logic [7:0] mask,
                    input string tag);
    access(1'b0, a, 8'h00, 1'b1, exp, mask, tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [13:0] a;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(mod_ce_n == 2'b11 && mod_rst == 2'b00 && ts_en == 2'b00 && irq == 1'b0
          && tuner_rst_n == 2'b11 && ts_out_en == 2'b00, "R1 outputs",
          {mod_ce_n, mod_rst, ts_en, tuner_rst_n}, 8'hC3);
    rd(A_CTRL,  8'h03, 8'hFF, "R1 ctrl");
    rd(A_CTRL2, 8'h0C, 8'hFF, "R1 R11 ctrl2");
    rd(A_IRQ,   8'h00, 8'hFF, "R1 irq");

    // R2 address split
    wr(A_ALO, 8'h2B);
    wr(A_AHI, 8'hB3);
    rd(A_ALO, 8'h2A, 8'hFF, "R2 alo");
    rd(A_AHI, 8'h33, 8'hFF, "R2 ahi");
    a = {7'h33, 7'h15};
    check(mod_addr == a, "R2 mod_addr", mod_addr, a);

    // R3 read, slot 0, control space; R5 phases
    wr(A_CTRL, 8'h40);
    rd(A_DATA, model(a, 1'b1, 1'b0), 8'hFF, "R3 read ctl slot0");
    check(n_setup == SETUP && n_pulse == PULSE && n_hold == HOLD, "R5 read phases",
          n_setup * 100 + n_pulse * 10 + n_hold, SETUP * 100 + PULSE * 10 + HOLD);
    // R3 read, slot 1, attribute memory
    wr(A_CTRL, 8'h80);
    rd(A_DATA, model(a, 1'b0, 1'b1), 8'hFF, "R3 read attr slot1");

    // R4 write, slot 0, attribute memory
    wr(A_CTRL, 8'h00);
    wr(A_DATA, 8'hC7);
    check(w_data == 8'hC7 && w_ce == 2'b10 && w_space == 1'b0 && w_addr == a, "R4 write",
          {w_ce, w_space, w_data}, {2'b10, 1'b0, 8'hC7});
    check(n_setup == SETUP && n_pulse == PULSE && n_hold == HOLD, "R5 write phases",
          n_setup * 100 + n_pulse * 10 + n_hold, SETUP * 100 + PULSE * 10 + HOLD);

    // R10 stream gates
    wr(A_CTRL, 8'h08);
    check(ts_en == 2'b01, "R10 ts_en slot0", ts_en, 2'b01);
    wr(A_CTRL, 8'h04);
    check(ts_en == 2'b10, "R10 ts_en slot1", ts_en, 2'b10);
    wr(A_CTRL2, 8'h1C);
    check(ts_out_en == 2'b01, "R10 ts_out_en bit4", ts_out_en, 2'b01);
    wr(A_CTRL2, 8'h2C);
    check(ts_out_en == 2'b10, "R10 ts_out_en bit5", ts_out_en, 2'b10);
    // R11 tuner resets
    wr(A_CTRL2, 8'h04);
    check(tuner_rst_n == 2'b10, "R11 tuner slot0 low", tuner_rst_n, 2'b10);
    rd(A_CTRL2, 8'h04, 8'hFF, "R11 ctrl2 readback");
    wr(A_CTRL2, 8'h08);
    check(tuner_rst_n == 2'b01, "R11 tuner slot1 low", tuner_rst_n, 2'b01);
    wr(A_CTRL2, 8'h0C);

    // R7 reset slot 0, module ready
    n_rst0 = 0;
    wr(A_CTRL, 8'h20);
    rd(A_CTRL, 8'h20, 8'h20, "R7 reset bit busy");
    repeat (30) @(negedge clk);
    check(n_rst0 == RHOLD, "R7 reset hold length", n_rst0, RHOLD);
    rd(A_CTRL, 8'h00, 8'h20, "R7 reset bit cleared");

    // R8 reset slot 1 with module never ready
    mod_rdy = 2'b01;
    wr(A_CTRL, 8'h10);
    repeat (RHOLD + 8) @(negedge clk);
    check(mod_rst[1] == 1'b0, "R8 reset released", mod_rst[1], 0);
    rd(A_CTRL, 8'h10, 8'h10, "R8 still waiting");
    // R9 writing zero to the busy reset bit and to presence bits
    wr(A_CTRL, 8'h00);
    rd(A_CTRL, 8'h13, 8'h13, "R9 reset bit kept, presence unchanged");
    repeat (RTMO) @(negedge clk);
    rd(A_CTRL, 8'h00, 8'h10, "R8 timeout cleared");
    mod_rdy = 2'b11;

    // R12 glitch ignored
    card_det_n = 2'b10;
    repeat (2) @(negedge clk);
    card_det_n = 2'b11;
    repeat (15) @(negedge clk);
    check(irq == 1'b0, "R12 glitch no irq", irq, 0);
    rd(A_CTRL, 8'h03, 8'h03, "R12 glitch presence");

    // R12/R13 insertion slot 0
    card_det_n = 2'b10;
    repeat (15) @(negedge clk);
    check(irq == 1'b1, "R13 irq raised", irq, 1);
    rd(A_CTRL, 8'h01, 8'h03, "R12 slot0 present bit1");
    rd(A_IRQ, 8'h01, 8'hFF, "R13 irq read");
    rd(A_IRQ, 8'h00, 8'hFF, "R13 irq cleared");
    check(irq == 1'b0, "R13 irq port low", irq, 0);

    // R12 insertion slot 1
    card_det_n = 2'b00;
    repeat (15) @(negedge clk);
    rd(A_CTRL, 8'h00, 8'h03, "R12 slot1 present bit0");
    check(irq == 1'b1, "R13 irq on slot1", irq, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule